// File: doc/BRIEF.md
# Multiplexed Bus Memory Controller

This block connects a processor whose address and data share one set of bus lines to a word-wide memory made of byte-wide SRAM banks. Each bus cycle opens with an address phase: a one-clock address strobe pulse captures the address from the bus. It also captures the two bus-status lines, which say whether the cycle targets memory or I/O, and the two access-information lines, which say whether the cycle writes and whether it moves a single byte. All of these are held for the rest of the cycle, while the same lines carry data.

In the data phase a level read strobe or a write strobe does the transfer. The block drives a chip select, an output enable and one write enable per byte bank. Word writes and every read use all banks. A byte write enables only the bank named by the low latched address bit, so the other byte of the word is kept. The banks are modelled inside the block as arrays. The production memory is 8K words (WORD_AW = 13). The default is smaller to keep elaboration light. A single select output flags I/O-page cycles for the console device outside this block.

The bus runs at the processor's pace and there is no stall. The block never back-pressures a cycle, and the processor never waits on it. No valid/ready handshake is used.

Top module: `mbmc_top`

## Requirements
- R1: While reset is asserted, and after it until the first address strobe, mem_cs, mem_oe, mem_we, io_sel and bus_oe are all 0.
- R2: The address, status and access lines are captured only on a cycle with as_stb high. They are held while the bus lines carry data, so changes on bus_in during the data phase do not move the accessed word.
- R3: Banks are selected only for cycles whose latched status is 2'b00 (memory). For codes 2'b01, 2'b10 and 2'b11, mem_cs stays 0, nothing is written and the bus is not driven.
- R4: io_sel is 1 exactly during cycles whose latched status is 2'b01 (I/O page), and it is never high together with mem_cs.
- R5: A word write (acc_info = 2'b10) with wr_stb high in a selected cycle drives mem_we = 2'b11 and stores all of bus_in at the latched word.
- R6: A byte write (acc_info = 2'b11) at an even address (latched bit 0 = 0) drives mem_we = 2'b01 and stores bus_in[7:0] into the low byte only. The high byte is kept.
- R7: A byte write at an odd address (latched bit 0 = 1) drives mem_we = 2'b10 and stores bus_in[15:8] into the high byte only. The low byte is kept.
- R8: bus_oe and mem_oe are 1 only while rd_stb is high in a selected memory cycle. Then bus_out carries the full stored word. The bus is released as soon as rd_stb falls.
- R9: A memory-status cycle whose latched byte address lies at or above 2^(WORD_AW+1) is ignored: mem_cs stays 0, the bus is not driven and no stored word changes.
- R10: The word address is latched bits WORD_AW:1. A word read at the odd byte address returns the same word as at the even address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | DW | Shared lines as seen by the block: address in the address phase, write data in the data phase |
| as_stb | input | 1 | One-clock address-phase pulse; captures the latch |
| bus_stat | input | 2 | Cycle class: 00 memory, 01 I/O page, 10 other I/O, 11 no transfer |
| acc_info | input | 2 | Access type: bit 1 write, bit 0 byte |
| rd_stb | input | 1 | Read strobe, level |
| wr_stb | input | 1 | Write strobe; the store happens on the clock edge while it is high |
| bus_out | output | DW | Read data toward the shared lines |
| bus_oe | output | 1 | Drive enable for bus_out |
| mem_cs | output | 1 | Chip select for all banks |
| mem_oe | output | 1 | Output enable for all banks |
| mem_we | output | DW/8 | Per-bank write enable, bit 0 = low byte |
| io_sel | output | 1 | I/O-page cycle select |

## Verification
The bench builds the block with DW = 16 and WORD_AW = 5, so there are 32 words. At that size random addresses often fall above the populated range, which exercises the ignore path. The same size lets the bench fill and model every word, so any stray byte-lane or out-of-range write shows up on a later read. Directed cycles cover byte merges on both lanes, odd-address word aliasing and writes under non-memory status.

// File: rtl/mbmc_pkg.sv
package mbmc_pkg;
  typedef enum logic [1:0] {
    ST_MEM    = 2'b00,
    ST_IOPAGE = 2'b01,
    ST_EXTIO  = 2'b10,
    ST_NONE   = 2'b11
  } bus_stat_e;

  typedef struct packed {
    logic wr;
    logic byte_op;
  } acc_t;
endpackage

// File: rtl/mbmc_addr_latch.sv
module mbmc_addr_latch
  import mbmc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_stb,
  input  logic [DW-1:0] bus_in,
  input  logic [1:0]    stat_in,
  input  logic [1:0]    acc_in,
  output logic [DW-1:0] la_q,
  output bus_stat_e     stat_q,
  output acc_t          acc_q,
  output logic          cyc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_q   <= '0;
      stat_q <= ST_NONE;
      acc_q  <= '0;
      cyc_q  <= 1'b0;
    end else if (as_stb) begin
      la_q   <= bus_in;
      stat_q <= bus_stat_e'(stat_in);
      acc_q  <= acc_t'(acc_in);
      cyc_q  <= 1'b1;
    end
  end

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !as_stb |=> $stable(la_q));
endmodule

// File: rtl/mbmc_lane_decode.sv
module mbmc_lane_decode
  import mbmc_pkg::*;
#(
  parameter int DW      = 16,
  parameter int WORD_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DW-1:0]      la_q,
  input  bus_stat_e          stat_q,
  input  acc_t               acc_q,
  input  logic               cyc_q,
  input  logic               rd_stb,
  input  logic               wr_stb,
  output logic               mem_cs,
  output logic               mem_oe,
  output logic [DW/8-1:0]    mem_we,
  output logic               io_sel,
  output logic [WORD_AW-1:0] word_addr
);
  localparam int NLANE     = DW / 8;
  localparam int LANE_BITS = (NLANE > 1) ? $clog2(NLANE) : 1;
  localparam int TOP_BIT   = WORD_AW + LANE_BITS;

  logic in_range;
  logic lane_wr;

  generate
    if (TOP_BIT < DW) begin : g_range
      assign in_range = (la_q[DW-1:TOP_BIT] == '0);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign word_addr = la_q[TOP_BIT-1:LANE_BITS];
  assign mem_cs    = cyc_q && (stat_q == ST_MEM) && in_range;
  assign mem_oe    = mem_cs && rd_stb;
  assign io_sel    = cyc_q && (stat_q == ST_IOPAGE);
  assign lane_wr   = mem_cs && wr_stb && acc_q.wr;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    always_comb begin
      if (!lane_wr)            mem_we[i] = 1'b0;
      else if (!acc_q.byte_op) mem_we[i] = 1'b1;
      else                     mem_we[i] = (la_q[LANE_BITS-1:0] == LANE_BITS'(i));
    end
  end

  p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mem_we) && acc_q.byte_op) |-> ($countones(mem_we) == 1));
  p_we_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> (mem_cs && wr_stb));
  p_io_mem_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_sel && mem_cs));
endmodule

// File: rtl/mbmc_byte_bank.sv
module mbmc_byte_bank #(
  parameter int WORD_AW = 10
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WORD_AW-1:0] addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata
);
  localparam int DEPTH = 1 << WORD_AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/mbmc_top.sv
module mbmc_top
  import mbmc_pkg::*;
#(
  parameter int DW      = 16,
  parameter int WORD_AW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   bus_in,
  input  logic            as_stb,
  input  logic [1:0]      bus_stat,
  input  logic [1:0]      acc_info,
  input  logic            rd_stb,
  input  logic            wr_stb,
  output logic [DW-1:0]   bus_out,
  output logic            bus_oe,
  output logic            mem_cs,
  output logic            mem_oe,
  output logic [DW/8-1:0] mem_we,
  output logic            io_sel
);
  localparam int NLANE = DW / 8;

  logic [DW-1:0]      la_q;
  bus_stat_e          stat_q;
  acc_t               acc_q;
  logic               cyc_q;
  logic [WORD_AW-1:0] word_addr;

  mbmc_addr_latch #(.DW(DW)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_stb  (as_stb),
    .bus_in  (bus_in),
    .stat_in (bus_stat),
    .acc_in  (acc_info),
    .la_q    (la_q),
    .stat_q  (stat_q),
    .acc_q   (acc_q),
    .cyc_q   (cyc_q)
  );

  mbmc_lane_decode #(.DW(DW), .WORD_AW(WORD_AW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .la_q      (la_q),
    .stat_q    (stat_q),
    .acc_q     (acc_q),
    .cyc_q     (cyc_q),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .mem_cs    (mem_cs),
    .mem_oe    (mem_oe),
    .mem_we    (mem_we),
    .io_sel    (io_sel),
    .word_addr (word_addr)
  );

  for (genvar i = 0; i < NLANE; i++) begin : g_bank
    mbmc_byte_bank #(.WORD_AW(WORD_AW)) u_bank (
      .clk   (clk),
      .we    (mem_we[i]),
      .addr  (word_addr),
      .wdata (bus_in[8*i +: 8]),
      .rdata (bus_out[8*i +: 8])
    );
  end

  assign bus_oe = mem_oe;

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (rd_stb && mem_cs));
  p_cs_memory_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> (stat_q == ST_MEM));
endmodule

// File: tb/mbmc_top_bench.sv
module mbmc_top_bench;
  localparam int DW      = 16;
  localparam int WORD_AW = 5;
  localparam int NW      = 1 << WORD_AW;
  localparam int LIMIT   = 2 * NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] bus_in = '0;
  logic          as_stb = 1'b0;
  logic [1:0]    bus_stat = 2'b11;
  logic [1:0]    acc_info = 2'b00;
  logic          rd_stb = 1'b0;
  logic          wr_stb = 1'b0;
  logic [DW-1:0] bus_out;
  logic          bus_oe, mem_cs, mem_oe, io_sel;
  logic [1:0]    mem_we;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [NW];

  always #10 clk = ~clk;

  mbmc_top #(.DW(DW), .WORD_AW(WORD_AW)) u_mbmc_top (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .as_stb(as_stb),
    .bus_stat(bus_stat), .acc_info(acc_info), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .bus_out(bus_out), .bus_oe(bus_oe), .mem_cs(mem_cs), .mem_oe(mem_oe),
    .mem_we(mem_we), .io_sel(io_sel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit sel_exp(input logic [15:0] a, input logic [1:0] st);
    return (st == 2'b00) && (a < LIMIT);
  endfunction

  function automatic logic [1:0] we_exp(input logic [15:0] a, input logic [1:0] st,
                                        input logic [1:0] acc);
    if (!sel_exp(a, st) || !acc[1]) return 2'b00;
    if (!acc[0]) return 2'b11;
    return a[0] ? 2'b10 : 2'b01;
  endfunction

  task automatic addr_phase(input logic [15:0] a, input logic [1:0] st,
                            input logic [1:0] acc);
    @(negedge clk);
    bus_in = a; bus_stat = st; acc_info = acc; as_stb = 1'b1;
    @(negedge clk);
    as_stb = 1'b0;
    bus_stat = 2'($urandom); acc_info = 2'($urandom);
    bus_in = 16'($urandom);
    #2;
    check(mem_cs == sel_exp(a, st), "R3/R9 mem_cs", 32'(mem_cs), 32'(sel_exp(a, st)));
    check(io_sel == (st == 2'b01), "R4 io_sel", 32'(io_sel), 32'(st == 2'b01));
  endtask

  task automatic wr_cycle(input logic [15:0] a, input logic [1:0] st,
                          input logic [1:0] acc, input logic [15:0] d);
    logic [1:0] ew;
    addr_phase(a, st, acc);
    ew = we_exp(a, st, acc);
    bus_in = d; wr_stb = 1'b1;
    #2;
    check(mem_we == ew, "R5/R6/R7 mem_we", 32'(mem_we), 32'(ew));
    @(negedge clk);
    wr_stb = 1'b0;
    if (ew[0]) model[a[WORD_AW:1]][7:0]  = d[7:0];
    if (ew[1]) model[a[WORD_AW:1]][15:8] = d[15:8];
  endtask

  task automatic rd_cycle(input logic [15:0] a, input logic [1:0] st, input string req);
    bit s;
    addr_phase(a, st, {1'b0, 1'($urandom)});
    s = sel_exp(a, st);
    rd_stb = 1'b1;
    #2;
    check(bus_oe == s && mem_oe == s, "R8 bus_oe during read", 32'({bus_oe, mem_oe}),
          32'({s, s}));
    if (s) check(bus_out == model[a[WORD_AW:1]], req, 32'(bus_out),
                 32'(model[a[WORD_AW:1]]));
    @(negedge clk);
    rd_stb = 1'b0;
    #2;
    check(bus_oe == 1'b0, "R8 release", 32'(bus_oe), 32'd0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2417));
    repeat (3) @(negedge clk);
    check({mem_cs, mem_oe, mem_we, io_sel, bus_oe} == 6'd0, "R1 in reset",
          32'({mem_cs, mem_oe, mem_we, io_sel, bus_oe}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd_stb = 1'b1; wr_stb = 1'b1;
    #2;
    check({mem_cs, mem_oe, mem_we, io_sel, bus_oe} == 6'd0, "R1 after reset",
          32'({mem_cs, mem_oe, mem_we, io_sel, bus_oe}), 32'd0);
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;

    for (int w = 0; w < NW; w++) wr_cycle(16'(2 * w), 2'b00, 2'b10, 16'($urandom));

    // directed: word then byte merges (R5 R6 R7)
    wr_cycle(16'd4, 2'b00, 2'b10, 16'h1234);
    rd_cycle(16'd4, 2'b00, "R5 word store");
    wr_cycle(16'd4, 2'b00, 2'b11, 16'hFFAB);
    rd_cycle(16'd4, 2'b00, "R6 even byte merge");
    check(model[2] == 16'h12AB, "R6 model", 32'(model[2]), 32'h12AB);
    wr_cycle(16'd5, 2'b00, 2'b11, 16'hCDFF);
    rd_cycle(16'd4, 2'b00, "R7 odd byte merge");
    // R10: odd word read aliases the even word
    rd_cycle(16'd5, 2'b00, "R10 odd alias read");
    // R9: out-of-range write must not alias onto word 2
    wr_cycle(16'(LIMIT + 4), 2'b00, 2'b10, 16'hDEAD);
    rd_cycle(16'd4, 2'b00, "R9 unchanged after out-of-range write");
    rd_cycle(16'(LIMIT + 4), 2'b00, "R9 out-of-range read");
    // R3: non-memory status writes ignored
    wr_cycle(16'd6, 2'b10, 2'b10, 16'hBEEF);
    wr_cycle(16'd6, 2'b01, 2'b11, 16'hBEEF);
    rd_cycle(16'd6, 2'b00, "R3 unchanged after non-memory write");
    // R2: data-phase bus noise does not move the word (bus_in randomised in addr_phase)
    rd_cycle(16'd62, 2'b00, "R2 latched word held");

    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      logic [1:0]  st;
      a  = ($urandom_range(0, 9) < 7) ? 16'($urandom_range(0, LIMIT - 1))
                                       : 16'($urandom_range(LIMIT, 65535));
      st = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      if ($urandom_range(0, 1) == 1)
        wr_cycle(a, st, {1'b1, 1'($urandom)}, 16'($urandom));
      else
        rd_cycle(a, st, "R5/R6/R7/R10 random read");
    end
    for (int w = 0; w < NW; w++) rd_cycle(16'(2 * w), 2'b00, "R9/R3 final sweep");
    finish_run();
  end
endmodule